// File: doc/BRIEF.md
# Interrupt Vector Generator with Fast-Interrupt Override

This block looks at a vector of pending interrupt request lines, picks the single winner, and produces the 21-bit address the processor should fetch from next. Each request line has its own programmable two-bit level. Level 0 disables the line, and levels 1 to 3 rank it. Within one level, the lower-numbered line wins. For a normal winner, the address is a table slot. The upper 13 bits come from a programmable table base. The low 8 bits are the winner's number shifted left by one.

Two fast channels can each name one request line by its number. When the named line is pending and programmed to level 2, it rises above every other level-2 request, whatever its number. It then bypasses the table and vectors to a full 21-bit address held in that channel's low and high address registers. Channel 0 outranks channel 1. Level 3 still outranks both channels.

All configuration sits behind a small synchronous 16-bit register bus: an address, a write strobe, write data and combinational read data. The outputs follow the pending lines and the registers combinationally, with no added cycle.

Top module: `irq_vector_gen`

## Requirements
- R1: After reset, every register reads 0. With any pending pattern, irqValid, vecNum, fetchAddr and isFast are all 0, because every line sits at level 0.
- R2: Register map on regAddr:
  - 0 holds the table base, bits 12:0.
  - 1 and 4 hold the channel 0 and channel 1 match numbers, bits 6:0. Bits 15:7 read 0 and ignore writes.
  - 2 and 5 hold the channel 0 and channel 1 address bits 15:0.
  - 3 and 6 hold the channel 0 and channel 1 address bits 20:16, in data bits 4:0.
  - 8+k holds the levels of lines 8k..8k+7, with line 8k+i in bits 2i+1:2i.
  - Unmapped addresses read 0. Unused bits read 0.
- R3: irqValid is 1 exactly when some pending line has a nonzero level. While irqValid is 0, vecNum, fetchAddr and isFast are 0.
- R4: Among normal requests, the higher level wins.
- R5: Among requests of equal rank, the lowest line number wins.
- R6: For a normal winner, fetchAddr = {base[12:0], vecNum, 1'b0} and isFast = 0.
- R7: A pending line whose number equals a channel's match value and whose level is 2 wins over every other level-2 and level-1 request. fetchAddr then equals that channel's {high[4:0], low[15:0]}, and isFast = 1.
- R8: When both channels qualify, channel 0 wins. If both channels name the same line, channel 0's address is used.
- R9: A matched line whose level is not 2 gets normal treatment: its normal rank and a table address.
- R10: A level-3 request outranks any fast request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data (combinational) |
| irqPending | input | NUM_IRQ | Pending request lines |
| irqValid | output | 1 | Some enabled line is pending |
| vecNum | output | 7 | Winning line number |
| fetchAddr | output | 21 | Address to fetch from |
| isFast | output | 1 | Winner took a fast channel |

## Verification
The bench builds the block with the default of 32 request lines. This gives four level registers, so the map is exercised up to address 11 and addresses above it read as unmapped. With 32 lines, a match value can also name a line that does not exist; such a channel must never fire. Random pending patterns are mixed with random register writes. This drives the fast ranks, the level-3 override and ties between equal ranks against a behavioural model on every cycle.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  localparam int VEC_W  = 7;
  localparam int ADDR_W = 21;
  localparam int BASE_W = 13;
  localparam int FHI_W  = ADDR_W - 16;
  localparam int BUS_W  = 16;
  localparam int REG_AW = 5;
  localparam int NUM_FAST = 2;
  localparam int LVL_PER_REG = BUS_W / 2;

  localparam logic [REG_AW-1:0] A_BASE = 5'd0;
  localparam logic [REG_AW-1:0] A_LVL0 = 5'd8;

  // Rank codes used by the arbiter, higher wins
  localparam logic [2:0] RANK_F1 = 3'd3;
  localparam logic [2:0] RANK_F0 = 3'd4;
  localparam logic [2:0] RANK_L3 = 3'd5;

  typedef struct packed {
    logic             valid;
    logic             fast0;
    logic             fast1;
    logic [VEC_W-1:0] vecNum;
  } arbSel_t;
endpackage

// File: rtl/ivg_ctrl.sv
module ivg_ctrl
  import ivg_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0]          irqPending,
  input  logic [NUM_IRQ-1:0][1:0]     lvl,
  input  logic [NUM_FAST-1:0][VEC_W-1:0] fastMatch,
  output arbSel_t                     sel
);
  always_comb begin
    logic [2:0] best;
    logic [2:0] rank;
    logic       hit0;
    logic       hit1;
    best = 3'd0;
    sel  = '0;
    // Descending scan with >= so the lowest index wins ties
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      hit0 = (lvl[i] == 2'd2) && (fastMatch[0] == VEC_W'(i));
      hit1 = (lvl[i] == 2'd2) && (fastMatch[1] == VEC_W'(i)) && !hit0;
      if (lvl[i] == 2'd3)  rank = RANK_L3;
      else if (hit0)       rank = RANK_F0;
      else if (hit1)       rank = RANK_F1;
      else                 rank = {1'b0, lvl[i]};
      if (irqPending[i] && (lvl[i] != 2'd0) && (rank >= best)) begin
        best       = rank;
        sel.valid  = 1'b1;
        sel.fast0  = hit0;
        sel.fast1  = hit1;
        sel.vecNum = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/ivg_datapath.sv
module ivg_datapath
  import ivg_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [REG_AW-1:0]             regAddr,
  input  logic                          regWrEn,
  input  logic [BUS_W-1:0]              regWrData,
  output logic [BUS_W-1:0]              regRdData,
  input  arbSel_t                       sel,
  output logic [NUM_IRQ-1:0][1:0]       lvl,
  output logic [NUM_FAST-1:0][VEC_W-1:0] fastMatch,
  output logic                          irqValid,
  output logic [VEC_W-1:0]              vecNum,
  output logic [ADDR_W-1:0]             fetchAddr,
  output logic                          isFast
);
  localparam int LVL_REGS = NUM_IRQ / LVL_PER_REG;

  logic [BASE_W-1:0]                 baseReg;
  logic [NUM_FAST-1:0][15:0]         fastLo;
  logic [NUM_FAST-1:0][FHI_W-1:0]    fastHi;

  always_ff @(posedge clk) begin
    if (!rstN) baseReg <= '0;
    else if (regWrEn && regAddr == A_BASE) baseReg <= regWrData[BASE_W-1:0];
  end

  for (genvar c = 0; c < NUM_FAST; c++) begin : gFast
    localparam logic [REG_AW-1:0] A_M  = REG_AW'(1 + 3 * c);
    localparam logic [REG_AW-1:0] A_LO = REG_AW'(2 + 3 * c);
    localparam logic [REG_AW-1:0] A_HI = REG_AW'(3 + 3 * c);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fastMatch[c] <= '0;
        fastLo[c]    <= '0;
        fastHi[c]    <= '0;
      end else if (regWrEn) begin
        if (regAddr == A_M)  fastMatch[c] <= regWrData[VEC_W-1:0];
        if (regAddr == A_LO) fastLo[c]    <= regWrData;
        if (regAddr == A_HI) fastHi[c]    <= regWrData[FHI_W-1:0];
      end
    end
  end

  for (genvar k = 0; k < LVL_REGS; k++) begin : gLvl
    always_ff @(posedge clk) begin
      if (!rstN) lvl[LVL_PER_REG*k +: LVL_PER_REG] <= '0;
      else if (regWrEn && regAddr == REG_AW'(A_LVL0 + k))
        lvl[LVL_PER_REG*k +: LVL_PER_REG] <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == A_BASE) regRdData[BASE_W-1:0] = baseReg;
    for (int c = 0; c < NUM_FAST; c++) begin
      if (regAddr == REG_AW'(1 + 3 * c)) regRdData[VEC_W-1:0] = fastMatch[c];
      if (regAddr == REG_AW'(2 + 3 * c)) regRdData = fastLo[c];
      if (regAddr == REG_AW'(3 + 3 * c)) regRdData[FHI_W-1:0] = fastHi[c];
    end
    for (int k = 0; k < LVL_REGS; k++)
      if (regAddr == REG_AW'(A_LVL0 + k)) regRdData = lvl[LVL_PER_REG*k +: LVL_PER_REG];
  end

  always_comb begin
    irqValid = sel.valid;
    isFast   = sel.fast0 | sel.fast1;
    vecNum   = sel.valid ? sel.vecNum : '0;
    if (sel.fast0)      fetchAddr = {fastHi[0], fastLo[0]};
    else if (sel.fast1) fetchAddr = {fastHi[1], fastLo[1]};
    else if (sel.valid) fetchAddr = {baseReg, sel.vecNum, 1'b0};
    else                fetchAddr = '0;
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import ivg_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [4:0]         regAddr,
  input  logic               regWrEn,
  input  logic [15:0]        regWrData,
  output logic [15:0]        regRdData,
  input  logic [NUM_IRQ-1:0] irqPending,
  output logic               irqValid,
  output logic [6:0]         vecNum,
  output logic [20:0]        fetchAddr,
  output logic               isFast
);
  arbSel_t                        sel;
  logic [NUM_IRQ-1:0][1:0]        lvl;
  logic [NUM_FAST-1:0][VEC_W-1:0] fastMatch;

  ivg_ctrl #(.NUM_IRQ(NUM_IRQ)) ctrl_i (
    .irqPending(irqPending),
    .lvl(lvl),
    .fastMatch(fastMatch),
    .sel(sel)
  );

  ivg_datapath #(.NUM_IRQ(NUM_IRQ)) dp_i (
    .clk(clk),
    .rstN(rstN),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .sel(sel),
    .lvl(lvl),
    .fastMatch(fastMatch),
    .irqValid(irqValid),
    .vecNum(vecNum),
    .fetchAddr(fetchAddr),
    .isFast(isFast)
  );
endmodule

// File: rtl/ivg_checker.sv
module ivg_checker #(
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [4:0]         regAddr,
  input logic [15:0]        regRdData,
  input logic [NUM_IRQ-1:0] irqPending,
  input logic               irqValid,
  input logic [6:0]         vecNum,
  input logic [20:0]        fetchAddr,
  input logic               isFast
);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (vecNum == 7'd0 && fetchAddr == 21'd0 && !isFast));

  // R3
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((irqPending & (NUM_IRQ'(1) << vecNum)) != '0));

  // R6
  table_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !isFast) |-> (fetchAddr[7:0] == {vecNum, 1'b0}));

  // R7
  fast_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    isFast |-> irqValid);

  // R2
  match_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 5'd1 || regAddr == 5'd4) |-> (regRdData[15:7] == 9'd0));
endmodule

bind irq_vector_gen ivg_checker #(.NUM_IRQ(NUM_IRQ)) chk_i (.*);

// File: tb/irq_vector_gen_tb.sv
`timescale 1ns/100ps
module irq_vector_gen_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [15:0]   regWrData = '0;
  logic [15:0]   regRdData;
  logic [N-1:0]  irqPending = '0;
  logic          irqValid;
  logic [6:0]    vecNum;
  logic [20:0]   fetchAddr;
  logic          isFast;

  int nChecks = 0;
  int nFail = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  // behavioural model state
  int mBase;
  int mMatch[2];
  int mLo[2];
  int mHi[2];
  int mLvl[N];

  always #2.5 clk = ~clk;

  irq_vector_gen #(.NUM_IRQ(N)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelClear();
    mBase = 0;
    for (int c = 0; c < 2; c++) begin mMatch[c] = 0; mLo[c] = 0; mHi[c] = 0; end
    for (int i = 0; i < N; i++) mLvl[i] = 0;
  endtask

  function automatic int modelRead(int a);
    if (a == 0) return mBase;
    if (a == 1 || a == 4) return mMatch[(a - 1) / 3];
    if (a == 2 || a == 5) return mLo[(a - 2) / 3];
    if (a == 3 || a == 6) return mHi[(a - 3) / 3];
    if (a >= 8 && a < 8 + N / 8) begin
      int v = 0;
      for (int i = 0; i < 8; i++) v |= mLvl[(a - 8) * 8 + i] << (2 * i);
      return v;
    end
    return 0;
  endfunction

  task automatic modelWrite(int a, int d);
    if (a == 0) mBase = d & 16'h1FFF;
    else if (a == 1 || a == 4) mMatch[(a - 1) / 3] = d & 16'h7F;
    else if (a == 2 || a == 5) mLo[(a - 2) / 3] = d & 16'hFFFF;
    else if (a == 3 || a == 6) mHi[(a - 3) / 3] = d & 16'h1F;
    else if (a >= 8 && a < 8 + N / 8)
      for (int i = 0; i < 8; i++) mLvl[(a - 8) * 8 + i] = (d >> (2 * i)) & 3;
  endtask

  // expected winner: returns valid, number, address, fast flag
  task automatic modelWin(output bit v, output int num, output int addr, output bit f);
    int best = 0;
    v = 0; num = 0; addr = 0; f = 0;
    for (int i = 0; i < N; i++) begin
      int r;
      int ch = -1;
      if (!irqPending[i] || mLvl[i] == 0) continue;
      if (mLvl[i] == 2 && mMatch[0] == i) ch = 0;
      else if (mLvl[i] == 2 && mMatch[1] == i) ch = 1;
      if (mLvl[i] == 3) r = 5;
      else if (ch == 0) r = 4;
      else if (ch == 1) r = 3;
      else r = mLvl[i];
      if (r > best) begin
        best = r; v = 1; num = i;
        if (ch >= 0) begin f = 1; addr = (mHi[ch] << 16) | mLo[ch]; end
        else begin f = 0; addr = (mBase << 8) | (i << 1); end
      end
    end
  endtask

  task automatic compareOut(string req);
    bit v; int num; int addr; bit f;
    modelWin(v, num, addr, f);
    chk({req, " valid"}, 32'(irqValid), 32'(v));
    chk({req, " vecNum"}, 32'(vecNum), 32'(num));
    chk({req, " fetchAddr"}, 32'(fetchAddr), 32'(addr));
    chk({req, " isFast"}, 32'(isFast), 32'(f));
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (running && rstN) begin
      bit v; int num; int addr; bit f;
      modelWin(v, num, addr, f);
      compareOut(f ? "R7" : (v ? "R6" : "R3"));
    end
  end

  task automatic busWrite(int a, int d);
    @(posedge clk); #1;
    regAddr = 5'(a); regWrData = 16'(d); regWrEn = 1'b1;
    @(posedge clk); #1;
    modelWrite(a, d);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(string req, int a);
    @(posedge clk); #1;
    regAddr = 5'(a); regWrEn = 1'b0;
    @(negedge clk);
    chk(req, 32'(regRdData), 32'(modelRead(a)));
  endtask

  task automatic setPend(logic [N-1:0] p);
    @(posedge clk); #1;
    irqPending = p;
  endtask

  task automatic setLvl(int line, int lv);
    int a = 8 + line / 8;
    int d = modelRead(a);
    d &= ~(3 << (2 * (line % 8)));
    d |= lv << (2 * (line % 8));
    busWrite(a, d);
  endtask

  task automatic sampleNow(string req);
    @(negedge clk);
    compareOut(req);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nChecks++; nFail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    modelClear();
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    running = 1'b1;

    // R1: reset values and quiet outputs
    for (int a = 0; a < 12; a++) busRead("R1 reset read", a);
    setPend('1);
    @(negedge clk);
    chk("R1 valid after reset", 32'(irqValid), 32'd0);
    chk("R1 addr after reset", 32'(fetchAddr), 32'd0);

    // R2: readback with masked widths
    for (int a = 0; a < 12; a++) busWrite(a, 16'hFFFF);
    for (int a = 0; a < 14; a++) busRead("R2 readback", a);
    busWrite(1, 16'hAB85);
    busRead("R2 match reserved bits", 1);
    for (int a = 0; a < 12; a++) busWrite(a, 0);
    setPend('0);

    // R3: pending but disabled
    setPend(32'h0000_0F00);
    sampleNow("R3 disabled lines");
    chk("R3 no valid", 32'(irqValid), 32'd0);

    // R5, R4, R6
    busWrite(0, 16'h1ABC);
    setLvl(5, 1); setLvl(9, 1);
    setPend(32'h0000_0220);
    sampleNow("R5 tie lowest");
    chk("R5 winner 5", 32'(vecNum), 32'd5);
    chk("R6 table addr", 32'(fetchAddr), 32'h1ABC0A);
    setLvl(12, 2);
    setPend(32'h0000_1220);
    sampleNow("R4 higher level");
    chk("R4 winner 12", 32'(vecNum), 32'd12);

    // R7: fast channel 0 on line 20
    busWrite(1, 20); busWrite(2, 16'h4321); busWrite(3, 16'h0015);
    setLvl(20, 2);
    setPend(32'h0010_1220);
    sampleNow("R7 fast0");
    chk("R7 fast addr", 32'(fetchAddr), 32'h154321);
    chk("R7 fast flag", 32'(isFast), 32'd1);

    // R8: both channels
    busWrite(4, 15); busWrite(5, 16'h9999); busWrite(6, 16'h0003);
    setLvl(15, 2);
    setPend(32'h0010_9000);
    sampleNow("R8 fast0 over fast1");
    chk("R8 winner 20", 32'(vecNum), 32'd20);
    setPend(32'h0000_9000);
    sampleNow("R7 fast1 alone");
    chk("R7 fast1 addr", 32'(fetchAddr), 32'h039999);
    busWrite(4, 20);
    setPend(32'h0010_0000);
    sampleNow("R8 same line");
    chk("R8 same line addr", 32'(fetchAddr), 32'h154321);
    busWrite(4, 15);

    // R9: matched line not at level 2
    setLvl(20, 1);
    setPend(32'h0010_1000);
    sampleNow("R9 match level 1");
    chk("R9 winner 12", 32'(vecNum), 32'd12);
    chk("R9 not fast", 32'(isFast), 32'd0);
    setLvl(20, 3);
    setPend(32'h0010_0000);
    sampleNow("R9 match level 3");
    chk("R9 table addr", 32'(fetchAddr), 32'h1ABC28);

    // R10: level 3 above fast
    setLvl(30, 3); setLvl(20, 2);
    setPend(32'h4010_8000);
    sampleNow("R10 level3 wins");
    chk("R10 winner 30", 32'(vecNum), 32'd30);

    // random mix, compared every clock
    for (int n = 0; n < 3000; n++) begin
      if (n % 8 == 0) begin
        int a = $urandom_range(0, 11);
        int d = $urandom & 16'hFFFF;
        if (a == 1 || a == 4) d = (d & 16'hFF80) | $urandom_range(0, 35);
        busWrite(a, d);
      end
      setPend(N'($urandom));
    end

    repeat (2) @(posedge clk);
    running = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule